// File: doc/BRIEF.md
# Segmented DAC Code Decoder

This block turns a 14-bit straight-binary sample into the switch drive pattern of a segmented current-steering converter. The word is split into three fields:

- The top five bits become a coarse group of 31 equal-weight thermometer lines.
- The next four bits become a fine group of 15 thermometer lines, each worth one sixteenth of a coarse line.
- The lowest five bits pass straight through as binary-weighted controls.

Every line is driven as a matched true/complement pair, so each current source is steered to exactly one of two output nodes, called A and B.

The sample is captured in an input register, decoded, and then loaded into an output register. All pairs change together on one clock edge. A sleep input travels down the pipeline with the data. When sleep is set, every current is parked on the B node.

Top module: `seg_dac_decoder`

## Requirements
- R1: While rst_ni is low, every A output (coarse_a_o, fine_a_o, lsb_a_o) is 0 and every B output is all ones.
- R2: Coarse line k (0..30) of coarse_a_o is 1 exactly when data_i[13:9], taken as unsigned, is greater than k.
- R3: Fine line k (0..14) of fine_a_o is 1 exactly when data_i[8:5], taken as unsigned, is greater than k.
- R4: lsb_a_o[i] equals data_i[i] for i in 0..4, with no decoding.
- R5: After reset, each B output is the bitwise inverse of its A output on every cycle.
- R6: An input sample or sleep level applied before a rising edge appears at the outputs after the second rising edge, and not earlier. This is a fixed two-cycle latency.
- R7: A sample taken with sleep_i = 1 produces all A outputs 0 and all B outputs all ones, whatever data_i holds.
- R8: Code 0 gives all A lines 0. Code 16383 gives all 31 coarse, 15 fine and 5 binary A lines at 1.
- R9: Each thermometer group is always contiguous from line 0 upward, with no isolated set or cleared lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Park all currents on the B node |
| data_i | input | 14 | Straight-binary sample code |
| coarse_a_o | output | 31 | Coarse thermometer lines, A side |
| coarse_b_o | output | 31 | Coarse thermometer lines, B side |
| fine_a_o | output | 15 | Fine thermometer lines, A side |
| fine_b_o | output | 15 | Fine thermometer lines, B side |
| lsb_a_o | output | 5 | Binary-weighted controls, A side |
| lsb_b_o | output | 5 | Binary-weighted controls, B side |

## Verification
The assertions check four things on every clock after reset:

- each B bus is the inverse of its A bus;
- each thermometer group has no bubbles;
- the set-line count of each group equals the field sampled two edges earlier, and the binary tail matches;
- a sleeping sample parks every current on B.

The bench scenarios show what the properties cannot. They cover the reset pattern held while reset is asserted and the exact output for the extreme codes and single-field boundary codes. They also show that a step input does not appear one cycle early.

// File: rtl/seg_dac_pkg.sv
package seg_dac_pkg;
  localparam int COARSE_W_DEF = 5;
  localparam int FINE_W_DEF   = 4;
  localparam int LSB_W_DEF    = 5;

  // number of unary lines produced from a w-bit field
  function automatic int therm_lines(input int w);
    return (1 << w) - 1;
  endfunction
endpackage

// File: rtl/seg_dac_in_reg.sv
module seg_dac_in_reg #(
  parameter int DW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          sleep_i,
  output logic [DW-1:0] data_o,
  output logic          sleep_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      sleep_o <= 1'b1;
    end else begin
      data_o  <= data_i;
      sleep_o <= sleep_i;
    end
  end
endmodule

// File: rtl/seg_dac_therm.sv
module seg_dac_therm #(
  parameter int IN_W  = 5,
  localparam int OUT_W = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  code_i,
  output logic [OUT_W-1:0] therm_o
);
  for (genvar k = 0; k < OUT_W; k++) begin : g_line
    assign therm_o[k] = (code_i > IN_W'(k));
  end
endmodule

// File: rtl/seg_dac_pair_reg.sv
module seg_dac_pair_reg #(
  parameter int W = 31
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         park_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] b_o
);
  // separate flop per polarity so both sides switch on the same edge
  for (genvar i = 0; i < W; i++) begin : g_pair
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_o[i] <= 1'b0;
        b_o[i] <= 1'b1;
      end else begin
        a_o[i] <= park_i ? 1'b0 : d_i[i];
        b_o[i] <= park_i ? 1'b1 : ~d_i[i];
      end
    end
  end
endmodule

// File: rtl/seg_dac_decoder.sv
module seg_dac_decoder #(
  parameter int COARSE_W = seg_dac_pkg::COARSE_W_DEF,
  parameter int FINE_W   = seg_dac_pkg::FINE_W_DEF,
  parameter int LSB_W    = seg_dac_pkg::LSB_W_DEF
) (
  input  logic                                        clk_i,
  input  logic                                        rst_ni,
  input  logic                                        sleep_i,
  input  logic [COARSE_W+FINE_W+LSB_W-1:0]            data_i,
  output logic [seg_dac_pkg::therm_lines(COARSE_W)-1:0] coarse_a_o,
  output logic [seg_dac_pkg::therm_lines(COARSE_W)-1:0] coarse_b_o,
  output logic [seg_dac_pkg::therm_lines(FINE_W)-1:0]   fine_a_o,
  output logic [seg_dac_pkg::therm_lines(FINE_W)-1:0]   fine_b_o,
  output logic [LSB_W-1:0]                              lsb_a_o,
  output logic [LSB_W-1:0]                              lsb_b_o
);
  localparam int DW    = COARSE_W + FINE_W + LSB_W;
  localparam int NC    = seg_dac_pkg::therm_lines(COARSE_W);
  localparam int NF    = seg_dac_pkg::therm_lines(FINE_W);
  localparam int C_LSB = FINE_W + LSB_W;

  logic [DW-1:0]       data_q;
  logic                sleep_q;
  logic [COARSE_W-1:0] coarse_fld;
  logic [FINE_W-1:0]   fine_fld;
  logic [LSB_W-1:0]    lsb_fld;
  logic [NC-1:0]       coarse_th;
  logic [NF-1:0]       fine_th;

  seg_dac_in_reg #(.DW(DW)) u_in (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .data_i (data_i),
    .sleep_i(sleep_i),
    .data_o (data_q),
    .sleep_o(sleep_q)
  );

  assign coarse_fld = data_q[DW-1 -: COARSE_W];
  assign fine_fld   = data_q[C_LSB-1 -: FINE_W];
  assign lsb_fld    = data_q[LSB_W-1:0];

  seg_dac_therm #(.IN_W(COARSE_W)) u_coarse_dec (
    .code_i (coarse_fld),
    .therm_o(coarse_th)
  );

  seg_dac_therm #(.IN_W(FINE_W)) u_fine_dec (
    .code_i (fine_fld),
    .therm_o(fine_th)
  );

  seg_dac_pair_reg #(.W(NC)) u_coarse_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .park_i(sleep_q),
    .d_i   (coarse_th),
    .a_o   (coarse_a_o),
    .b_o   (coarse_b_o)
  );

  seg_dac_pair_reg #(.W(NF)) u_fine_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .park_i(sleep_q),
    .d_i   (fine_th),
    .a_o   (fine_a_o),
    .b_o   (fine_b_o)
  );

  seg_dac_pair_reg #(.W(LSB_W)) u_lsb_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .park_i(sleep_q),
    .d_i   (lsb_fld),
    .a_o   (lsb_a_o),
    .b_o   (lsb_b_o)
  );
endmodule

// File: rtl/seg_dac_checker.sv
module seg_dac_checker #(
  parameter int COARSE_W = 5,
  parameter int FINE_W   = 4,
  parameter int LSB_W    = 5
) (
  input logic                                 clk_i,
  input logic                                 rst_ni,
  input logic                                 sleep_i,
  input logic [COARSE_W+FINE_W+LSB_W-1:0]     data_i,
  input logic [(1<<COARSE_W)-2:0]             coarse_a_o,
  input logic [(1<<COARSE_W)-2:0]             coarse_b_o,
  input logic [(1<<FINE_W)-2:0]               fine_a_o,
  input logic [(1<<FINE_W)-2:0]               fine_b_o,
  input logic [LSB_W-1:0]                     lsb_a_o,
  input logic [LSB_W-1:0]                     lsb_b_o
);
  localparam int DW    = COARSE_W + FINE_W + LSB_W;
  localparam int NC    = (1 << COARSE_W) - 1;
  localparam int NF    = (1 << FINE_W) - 1;
  localparam int C_LSB = FINE_W + LSB_W;

  logic [1:0] age_q;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end
  assign warm = (age_q == 2'd2);

  a_r5_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coarse_b_o == ~coarse_a_o) && (fine_b_o == ~fine_a_o) && (lsb_b_o == ~lsb_a_o));

  a_r9_coarse_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((({1'b0, coarse_a_o}) + (NC+1)'(1)) & {1'b0, coarse_a_o}) == '0);

  a_r9_fine_contig: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((({1'b0, fine_a_o}) + (NF+1)'(1)) & {1'b0, fine_a_o}) == '0);

  a_r2_coarse_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(sleep_i, 2)) |->
      ($countones(coarse_a_o) == int'($past(data_i[DW-1 -: COARSE_W], 2))));

  a_r3_fine_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(sleep_i, 2)) |->
      ($countones(fine_a_o) == int'($past(data_i[C_LSB-1 -: FINE_W], 2))));

  a_r4_lsb_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && !$past(sleep_i, 2)) |-> (lsb_a_o == $past(data_i[LSB_W-1:0], 2)));

  a_r7_sleep_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && $past(sleep_i, 2)) |->
      (coarse_a_o == '0) && (fine_a_o == '0) && (lsb_a_o == '0));
endmodule

bind seg_dac_decoder seg_dac_checker #(
  .COARSE_W(COARSE_W),
  .FINE_W  (FINE_W),
  .LSB_W   (LSB_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sleep_i   (sleep_i),
  .data_i    (data_i),
  .coarse_a_o(coarse_a_o),
  .coarse_b_o(coarse_b_o),
  .fine_a_o  (fine_a_o),
  .fine_b_o  (fine_b_o),
  .lsb_a_o   (lsb_a_o),
  .lsb_b_o   (lsb_b_o)
);

// File: tb/seg_dac_decoder_tb.sv
module seg_dac_decoder_tb;
  localparam int NC = 31;
  localparam int NF = 15;
  localparam int NL = 5;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          sleep_i = 1'b0;
  logic [13:0]   data_i = '0;
  logic [NC-1:0] coarse_a_o, coarse_b_o;
  logic [NF-1:0] fine_a_o, fine_b_o;
  logic [NL-1:0] lsb_a_o, lsb_b_o;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;
  bit  r6_mode = 1'b0;

  logic [13:0] h1_d, h2_d;
  logic        h1_s, h2_s;
  int          hv = 0;

  always #4 clk = ~clk;

  seg_dac_decoder u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .sleep_i   (sleep_i),
    .data_i    (data_i),
    .coarse_a_o(coarse_a_o),
    .coarse_b_o(coarse_b_o),
    .fine_a_o  (fine_a_o),
    .fine_b_o  (fine_b_o),
    .lsb_a_o   (lsb_a_o),
    .lsb_b_o   (lsb_b_o)
  );

  function automatic logic [NC-1:0] exp_coarse(input logic [13:0] d, input logic s);
    logic [NC-1:0] r = '0;
    for (int k = 0; k < NC; k++) if (int'(d[13:9]) > k) r[k] = 1'b1;
    return s ? '0 : r;
  endfunction

  function automatic logic [NF-1:0] exp_fine(input logic [13:0] d, input logic s);
    logic [NF-1:0] r = '0;
    for (int k = 0; k < NF; k++) if (int'(d[8:5]) > k) r[k] = 1'b1;
    return s ? '0 : r;
  endfunction

  function automatic logic [NL-1:0] exp_lsb(input logic [13:0] d, input logic s);
    return s ? '0 : d[4:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_outputs(input logic [13:0] d, input logic s);
    string t2, t3, t4;
    logic [NC-1:0] ec = exp_coarse(d, s);
    logic [NF-1:0] ef = exp_fine(d, s);
    logic [NL-1:0] el = exp_lsb(d, s);
    if (r6_mode)                        begin t2 = "R6"; t3 = "R6"; t4 = "R6"; end
    else if (s)                         begin t2 = "R7"; t3 = "R7"; t4 = "R7"; end
    else if (d == 14'd0 || d == 14'h3FFF) begin t2 = "R8"; t3 = "R8"; t4 = "R8"; end
    else                                begin t2 = "R2"; t3 = "R3"; t4 = "R4"; end
    chk(coarse_a_o == ec, t2, "coarse_a", 64'(coarse_a_o), 64'(ec));
    chk(fine_a_o == ef, t3, "fine_a", 64'(fine_a_o), 64'(ef));
    chk(lsb_a_o == el, t4, "lsb_a", 64'(lsb_a_o), 64'(el));
    chk((coarse_b_o == ~ec) && (fine_b_o == ~ef) && (lsb_b_o == ~el), "R5", "b_side",
        {coarse_b_o, fine_b_o, lsb_b_o}, {~ec, ~ef, ~el});
  endtask

  // one sample per clock: check the sample applied two negedges ago, then drive
  task automatic step(input logic [13:0] d, input logic s);
    @(negedge clk);
    if (hv >= 2) check_outputs(h2_d, h2_s);
    h2_d = h1_d; h2_s = h1_s;
    h1_d = d;    h1_s = s;
    if (hv < 2) hv++;
    data_i  = d;
    sleep_i = s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    data_i = 14'h3FFF;
    repeat (4) @(negedge clk);
    // R1: reset pattern held while reset is low, even with a full-scale input
    chk((coarse_a_o == '0) && (fine_a_o == '0) && (lsb_a_o == '0), "R1", "a_reset",
        {coarse_a_o, fine_a_o, lsb_a_o}, 64'd0);
    chk((&coarse_b_o) && (&fine_b_o) && (&lsb_b_o), "R1", "b_reset",
        {coarse_b_o, fine_b_o, lsb_b_o}, {{NC{1'b1}}, {NF{1'b1}}, {NL{1'b1}}});
    data_i = '0;
    rst_ni = 1'b1;

    // R8 extremes
    step(14'd0, 0); step(14'h3FFF, 0); step(14'd0, 0); step(14'h3FFF, 0);
    // R7: sleep overrides full scale
    step(14'h3FFF, 1); step(14'h1234, 1); step(14'h3FFF, 0);
    // R2/R3/R4 field boundaries
    step(14'd1 << 9, 0);  step(14'd31 << 9, 0); step(14'd1 << 5, 0);
    step(14'd15 << 5, 0); step(14'd1, 0);       step(14'd31, 0);
    step(14'h01FF, 0);    step(14'h3E00, 0);    step(14'h2AAA, 0);
    step(14'h1555, 0);
    // R6: step from zero must not show one cycle early
    step(14'd0, 0); step(14'd0, 0);
    r6_mode = 1'b1;
    step(14'h3FFF, 0); step(14'h3FFF, 0); step(14'd0, 1); step(14'd0, 0);
    step(14'd0, 0); step(14'd0, 0);
    r6_mode = 1'b0;

    for (int i = 0; i < 3000; i++)
      step(14'($urandom), ($urandom % 8) == 0);
    step(14'd0, 0); step(14'd0, 0); step(14'd0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule